// File: doc/BRIEF.md
# Display Power-Save Output Gating

This block sits between an LCD timing generator and the panel pins. In normal mode it passes the generator's pixel data, shift clock, line pulse, frame pulse, data-ready and TFT control lines to the panel, one register stage later. It also passes the generator's display-data fetch request on to the memory side. In power-save mode it drives every panel pin to a defined rest level and holds the fetch request low.

The rest level of a pin depends on the panel family. A panel-type input selects passive STN or high-resolution TFT, and for TFT panels a polarity bit also sets the shift clock's rest level. On a TFT panel, the frame pulse, the line pulse and the first three control lines keep the level they last carried. Power-save requests are taken only in a cycle that the generator marks as a frame boundary, so the panel never receives part of a frame. The block has no register-bus port, so host access to the control registers, the look-up table and video memory is never gated.

Top module: `disp_psave_gate`

## Requirements
- R1: While `rst_ni` is low, every output is 0 and the block is in normal mode. The block stays in normal mode until a power-save request is taken at a frame boundary.
- R2: In normal mode, each panel output and `fetch_req_o` equals the matching input as sampled at the previous clock edge.
- R3: The mode changes only at an edge where `frame_start_i` is 1. At that edge the mode becomes `psave_req_i`, and the outputs loaded at that edge already follow the new mode. A change on `psave_req_i` while `frame_start_i` is 0 has no effect.
- R4: In power-save, `pix_data_o` is all zeros for both panel types.
- R5: In power-save with `panel_tft_i` = 0 (STN), `shift_clk_o`, `line_pulse_o`, `frame_pulse_o`, `drdy_o` and all of `tft_ctl_o` are 0.
- R6: In power-save with `panel_tft_i` = 1 (TFT), `shift_clk_o` is 1 when `shift_pol_i` = 0 and is 0 when `shift_pol_i` = 1.
- R7: In power-save with TFT, `frame_pulse_o`, `line_pulse_o` and `tft_ctl_o[2:0]` keep the values they had in the last normal-mode cycle. They hold those values for as long as power-save lasts, whatever their inputs do.
- R8: In power-save with TFT, `tft_ctl_o[3]` and `drdy_o` are 0.
- R9: In power-save, `fetch_req_o` is 0, whatever `fetch_req_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psave_req_i | input | 1 | Requested mode: 1 = power-save, 0 = normal |
| frame_start_i | input | 1 | High in the generator's frame-boundary cycle |
| panel_tft_i | input | 1 | Panel family: 0 = STN, 1 = TFT |
| shift_pol_i | input | 1 | TFT shift-clock polarity setting |
| pix_data_i | input | DATA_W | Live pixel data |
| shift_clk_i | input | 1 | Live shift clock |
| line_pulse_i | input | 1 | Live line pulse |
| frame_pulse_i | input | 1 | Live frame pulse |
| drdy_i | input | 1 | Live data-ready |
| tft_ctl_i | input | CTL_W | Live TFT control lines |
| fetch_req_i | input | 1 | Display-data fetch request from the generator |
| pix_data_o | output | DATA_W | Pixel data pins |
| shift_clk_o | output | 1 | Shift clock pin |
| line_pulse_o | output | 1 | Line pulse pin |
| frame_pulse_o | output | 1 | Frame pulse pin |
| drdy_o | output | 1 | Data-ready pin |
| tft_ctl_o | output | CTL_W | TFT control pins |
| fetch_req_o | output | 1 | Gated fetch request |

## Verification
The bench builds the block with its default parameters: a 24-bit data bus and four control lines, of which bits 0 to 2 keep their level. With these values every rest behaviour is reachable: a frozen low, a frozen high and a forced-low control line all appear in the same word. Requests raised or dropped away from a frame boundary can be shown to have no effect. Both shift-clock polarities can be tried while the block is held in TFT power-save.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic {MODE_NORMAL = 1'b0, MODE_PSAVE = 1'b1} mode_e;

  typedef enum logic [1:0] {
    REST_LOW  = 2'd0,
    REST_HIGH = 2'd1,
    REST_HOLD = 2'd2
  } rest_e;

  // TFT shift clock rests opposite to its polarity setting
  function automatic logic tft_shift_rest(input logic pol);
    return ~pol;
  endfunction

  // rest rule for a line that is frozen on TFT and low on STN
  function automatic rest_e hold_or_low(input logic tft, input logic holdable);
    return (tft && holdable) ? REST_HOLD : REST_LOW;
  endfunction
endpackage

// File: rtl/dpg_mode_ctl.sv
module dpg_mode_ctl
  import dpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frame_start_i,
  input  logic  psave_req_i,
  output mode_e mode_d_o,
  output mode_e mode_q_o
);
  mode_e mode_q;

  always_comb begin
    mode_d_o = mode_q;
    if (frame_start_i) mode_d_o = psave_req_i ? MODE_PSAVE : MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_NORMAL;
    else         mode_q <= mode_d_o;
  end

  assign mode_q_o = mode_q;
endmodule

// File: rtl/dpg_pin_reg.sv
module dpg_pin_reg
  import dpg_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gate_i,
  input  rest_e        rest_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] pin_q, pin_d;

  always_comb begin
    pin_d = live_i;
    if (gate_i) begin
      unique case (rest_i)
        REST_HIGH: pin_d = '1;
        REST_HOLD: pin_d = pin_q;
        default:   pin_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/disp_psave_gate.sv
module disp_psave_gate
  import dpg_pkg::*;
#(
  parameter int          DATA_W   = 24,
  parameter int          CTL_W    = 4,
  parameter logic [CTL_W-1:0] CTL_HOLD = 4'b0111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psave_req_i,
  input  logic              frame_start_i,
  input  logic              panel_tft_i,
  input  logic              shift_pol_i,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic              shift_clk_i,
  input  logic              line_pulse_i,
  input  logic              frame_pulse_i,
  input  logic              drdy_i,
  input  logic [CTL_W-1:0]  tft_ctl_i,
  input  logic              fetch_req_i,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              shift_clk_o,
  output logic              line_pulse_o,
  output logic              frame_pulse_o,
  output logic              drdy_o,
  output logic [CTL_W-1:0]  tft_ctl_o,
  output logic              fetch_req_o
);
  mode_e mode_d, mode_q_e;
  logic  gate;
  logic  mode_q;
  rest_e shift_rest, pulse_rest;

  dpg_mode_ctl u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .psave_req_i  (psave_req_i),
    .mode_d_o     (mode_d),
    .mode_q_o     (mode_q_e)
  );

  assign gate   = (mode_d == MODE_PSAVE);
  assign mode_q = (mode_q_e == MODE_PSAVE);

  always_comb begin
    shift_rest = REST_LOW;
    if (panel_tft_i) shift_rest = tft_shift_rest(shift_pol_i) ? REST_HIGH : REST_LOW;
    pulse_rest = hold_or_low(panel_tft_i, 1'b1);
  end

  dpg_pin_reg #(.W(DATA_W)) u_pix (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate), .rest_i(REST_LOW),
    .live_i(pix_data_i), .pin_o(pix_data_o)
  );

  dpg_pin_reg #(.W(1)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate), .rest_i(shift_rest),
    .live_i(shift_clk_i), .pin_o(shift_clk_o)
  );

  dpg_pin_reg #(.W(1)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate), .rest_i(pulse_rest),
    .live_i(line_pulse_i), .pin_o(line_pulse_o)
  );

  dpg_pin_reg #(.W(1)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate), .rest_i(pulse_rest),
    .live_i(frame_pulse_i), .pin_o(frame_pulse_o)
  );

  dpg_pin_reg #(.W(1)) u_drdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate), .rest_i(REST_LOW),
    .live_i(drdy_i), .pin_o(drdy_o)
  );

  dpg_pin_reg #(.W(1)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate), .rest_i(REST_LOW),
    .live_i(fetch_req_i), .pin_o(fetch_req_o)
  );

  // per-line rest rule: masked lines freeze on TFT, the rest go low
  for (genvar i = 0; i < CTL_W; i++) begin : g_ctl
    rest_e ctl_rest;
    assign ctl_rest = hold_or_low(panel_tft_i, CTL_HOLD[i]);

    dpg_pin_reg #(.W(1)) u_ctl (
      .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate), .rest_i(ctl_rest),
      .live_i(tft_ctl_i[i]), .pin_o(tft_ctl_o[i])
    );
  end
endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int DATA_W = 24,
  parameter int CTL_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic              panel_tft_i,
  input logic              shift_pol_i,
  input logic [DATA_W-1:0] pix_data_i,
  input logic              fetch_req_i,
  input logic              mode_q,
  input logic [DATA_W-1:0] pix_data_o,
  input logic              shift_clk_o,
  input logic              line_pulse_o,
  input logic              frame_pulse_o,
  input logic              drdy_o,
  input logic [CTL_W-1:0]  tft_ctl_o,
  input logic              fetch_req_o
);
  a_r2_pix_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !mode_q) |-> (pix_data_o == $past(pix_data_i)));

  a_r2_fetch_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !mode_q) |-> (fetch_req_o == $past(fetch_req_i)));

  a_r3_boundary_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(frame_start_i)) |-> (mode_q == $past(mode_q)));

  a_r4_pix_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> (pix_data_o == '0));

  a_r5_stn_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_q && !$past(panel_tft_i)) |->
      (!shift_clk_o && !line_pulse_o && !frame_pulse_o && !drdy_o && tft_ctl_o == '0));

  a_r6_tft_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_q && $past(panel_tft_i)) |-> (shift_clk_o == !$past(shift_pol_i)));

  a_r7_tft_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_q && $past(mode_q) && $past(panel_tft_i)) |->
      ($stable(frame_pulse_o) && $stable(line_pulse_o) && $stable(tft_ctl_o[2:0])));

  a_r8_tft_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && mode_q && $past(panel_tft_i)) |-> (!tft_ctl_o[CTL_W-1] && !drdy_o));

  a_r9_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !fetch_req_o);
endmodule

bind disp_psave_gate dpg_checker #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .panel_tft_i  (panel_tft_i),
  .shift_pol_i  (shift_pol_i),
  .pix_data_i   (pix_data_i),
  .fetch_req_i  (fetch_req_i),
  .mode_q       (mode_q),
  .pix_data_o   (pix_data_o),
  .shift_clk_o  (shift_clk_o),
  .line_pulse_o (line_pulse_o),
  .frame_pulse_o(frame_pulse_o),
  .drdy_o       (drdy_o),
  .tft_ctl_o    (tft_ctl_o),
  .fetch_req_o  (fetch_req_o)
);

// File: tb/disp_psave_gate_bench.sv
`timescale 1ns/1ps
module disp_psave_gate_bench;
  localparam int DW = 24;
  localparam int CW = 4;
  localparam int NROW = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ps, fs, tft, pol, sc, lp, fp, dr, fe;
  logic [DW-1:0] pix;
  logic [CW-1:0] ctl;
  logic [DW-1:0] pix_o;
  logic sc_o, lp_o, fp_o, dr_o, fe_o;
  logic [CW-1:0] ctl_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  disp_psave_gate u_disp_psave_gate (
    .clk_i(clk), .rst_ni(rst_ni), .psave_req_i(ps), .frame_start_i(fs),
    .panel_tft_i(tft), .shift_pol_i(pol), .pix_data_i(pix), .shift_clk_i(sc),
    .line_pulse_i(lp), .frame_pulse_i(fp), .drdy_i(dr), .tft_ctl_i(ctl),
    .fetch_req_i(fe), .pix_data_o(pix_o), .shift_clk_o(sc_o),
    .line_pulse_o(lp_o), .frame_pulse_o(fp_o), .drdy_o(dr_o),
    .tft_ctl_o(ctl_o), .fetch_req_o(fe_o)
  );

  // stim: ps fs tft pol | pix | sc lp fp dr | ctl | fetch
  localparam logic [36:0] STIM [NROW] = '{
    {4'b0000, 24'h123456, 4'b1011, 4'h5, 1'b1},
    {4'b1000, 24'habcdef, 4'b0101, 4'ha, 1'b1},
    {4'b1100, 24'hffffff, 4'b1111, 4'hf, 1'b1},
    {4'b1000, 24'hffffff, 4'b1111, 4'hf, 1'b1},
    {4'b0000, 24'hffffff, 4'b1111, 4'hf, 1'b1},
    {4'b0100, 24'h00ff00, 4'b1001, 4'h3, 1'b1},
    {4'b0010, 24'h111111, 4'b0101, 4'hb, 1'b1},
    {4'b1110, 24'h222222, 4'b0011, 4'h4, 1'b1},
    {4'b1011, 24'h333333, 4'b1011, 4'hc, 1'b1},
    {4'b0111, 24'h444444, 4'b1010, 4'h8, 1'b0}
  };
  // expected: pix | sc lp fp dr | ctl | fetch
  localparam logic [32:0] EXP [NROW] = '{
    {24'h123456, 4'b1011, 4'h5, 1'b1},
    {24'habcdef, 4'b0101, 4'ha, 1'b1},
    {24'h000000, 4'b0000, 4'h0, 1'b0},
    {24'h000000, 4'b0000, 4'h0, 1'b0},
    {24'h000000, 4'b0000, 4'h0, 1'b0},
    {24'h00ff00, 4'b1001, 4'h3, 1'b1},
    {24'h111111, 4'b0101, 4'hb, 1'b1},
    {24'h000000, 4'b1100, 4'h3, 1'b0},
    {24'h000000, 4'b0100, 4'h3, 1'b0},
    {24'h444444, 4'b1010, 4'h8, 1'b0}
  };

  function automatic string row_req(input int i);
    case (i)
      0: return "R2 normal STN pass";
      1: return "R3 request without boundary ignored";
      2: return "R5 STN entry all low, R4, R9";
      3: return "R5 STN power-save held";
      4: return "R3 release without boundary ignored";
      5: return "R3 exit at boundary, R2";
      6: return "R2 normal TFT pass";
      7: return "R7 TFT entry freeze, R6 pol0 high, R8";
      8: return "R6 pol1 low, R7 held, R9";
      default: return "R3 TFT exit at boundary";
    endcase
  endfunction

  function automatic logic [32:0] outs();
    return {pix_o, sc_o, lp_o, fp_o, dr_o, ctl_o, fe_o};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [36:0] s);
    {ps, fs, tft, pol, pix, sc, lp, fp, dr, ctl, fe} = s;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset with busy inputs
    apply({4'b0000, 24'hffffff, 4'b1111, 4'hf, 1'b1});
    repeat (3) @(posedge clk);
    #1 check("R1 outputs low in reset", outs(), 33'd0);
    @(negedge clk) rst_ni = 1'b1;

    // vector table
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk) apply(STIM[i]);
      @(posedge clk);
      #1 check(row_req(i), outs(), EXP[i]);
    end

    // R7: TFT freeze held while inputs toggle; R8 ctl3 and drdy low
    @(negedge clk) apply({4'b0010, 24'h0, 4'b0110, 4'h7, 1'b1});
    @(posedge clk);
    @(negedge clk) apply({4'b1110, 24'h0, 4'b0000, 4'h0, 1'b1});
    @(posedge clk);
    #1 check("R7 entry freeze", outs(), {24'h0, 4'b1110, 4'h7, 1'b0});
    for (int k = 0; k < 5; k++) begin
      @(negedge clk) apply({2'b10, 2'b10, 24'h5a5a5a, k[0], ~k[0], k[0], 1'b1, {4{k[1]}}, 1'b1});
      @(posedge clk);
      #1 check("R7 hold, R8 ctl3 low", outs(), {24'h0, 4'b1110, 4'h7, 1'b0});
    end

    // R1: reset in the middle of power-save returns to normal
    @(negedge clk) rst_ni = 1'b0;
    #1 check("R1 async reset clears", outs(), 33'd0);
    @(negedge clk) rst_ni = 1'b1;
    apply({4'b0000, 24'h0c0ffe, 4'b1101, 4'h9, 1'b1});
    @(posedge clk);
    #1 check("R1 normal after reset", outs(), {24'h0c0ffe, 4'b1101, 4'h9, 1'b1});

    // R9: fetch request blocked for a whole power-save stretch
    @(negedge clk) apply({4'b1100, 24'h0, 4'b0000, 4'h0, 1'b1});
    @(posedge clk);
    #1 check("R9 fetch blocked", {32'd0, fe_o}, 33'd0);
    @(negedge clk) fe = 1'b1;
    @(posedge clk);
    #1 check("R9 fetch blocked held", {32'd0, fe_o}, 33'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule